// File: doc/BRIEF.md
# Processor-to-Memory Crossbar Switch with Per-Module Arbitration

This block joins sixteen processor ports to sixteen memory module ports in a shared-memory multiprocessor. Each processor raises a request that names a target module, an address, write data and a direction flag. For every request that wins, the crossbar closes one crosspoint for that cycle. The crosspoint forwards the request to the module, and it carries the read data back to the processor on the following cycle.

A memory module serves one access per cycle. Each module column therefore has its own round-robin arbiter. When several processors name the same module, exactly one of them wins. The others see a not-ready indication and hold their request until they win. Requests that go to different modules are all granted in the same cycle. The modules are expected to register read data, so read data appears on the module side one cycle after the access.

Top module: `pm_crossbar`

## Requirements
- R1: During reset, and on the first cycle after it, `p_rvalid` is low. Every arbitration pointer restarts at processor 0, so the lowest-numbered contender wins the first conflict on each module.
- R2: A processor that wins module m sees `p_ready` high in the same cycle. In that cycle `m_req[m]` is high, and `m_we[m]`, `m_addr[m]` and `m_wdata[m]` equal the winner's `p_we`, `p_addr` and `p_wdata`. `p_ready` is never high without `p_req`.
- R3: `m_req[m]` is high exactly when at least one processor requests module m. `p_target` is the 4-bit binary module index. When requests name pairwise distinct modules, all of them are granted in that cycle.
- R4: Among the processors that target one module, exactly one is granted. The winner is the first requester found by scanning upward from that module's pointer, wrapping from 15 to 0.
- R5: After a grant on module m, its pointer becomes the granted index plus one, modulo 16. In a cycle with no grant on that module, the pointer keeps its value.
- R6: A granted read produces a one-cycle `p_rvalid` pulse on the granting processor one cycle after the grant. In that cycle `p_rdata` equals the module's `m_rdata`.
- R7: A granted write produces no `p_rvalid` pulse.
- R8: At most one crosspoint is closed in each module column in any cycle, and at most one in each processor row.
- R9: A request that is held stable is granted within 16 cycles of being raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| p_req | input | 16 | Per-processor request valid |
| p_target | input | 16x4 | Per-processor target module index |
| p_we | input | 16 | Per-processor write flag (1 = write, 0 = read) |
| p_addr | input | 16x12 | Per-processor word address |
| p_wdata | input | 16x32 | Per-processor write data |
| p_ready | output | 16 | Request granted this cycle; low while stalled |
| p_rvalid | output | 16 | Read data valid, one cycle after a read grant |
| p_rdata | output | 16x32 | Read data returned to the processor |
| m_req | output | 16 | Access strobe per memory module |
| m_we | output | 16 | Write flag per memory module |
| m_addr | output | 16x12 | Address per memory module |
| m_wdata | output | 16x32 | Write data per memory module |
| m_rdata | input | 16x32 | Registered read data from each memory module |

## Verification
Grants and the forwarded module signals are combinational in the request cycle. The bench therefore drives each vector on the falling edge and compares `p_ready`, `m_req` and the forwarded fields one nanosecond later, in that same cycle. Read responses are due one rising edge later. The bench stores the expected valid flag and data at grant time and compares them after the next falling edge, just before the following request is judged. A bench model of the per-module pointers supplies the expected winner every cycle. It runs through a hot-spot storm, a set of rotating permutations and a long randomized contention mix.

// File: rtl/pmx_pkg.sv
package pmx_pkg;

    localparam int N_PROC = 16;
    localparam int N_MEM  = 16;
    localparam int ADDR_W = 12;
    localparam int DATA_W = 32;

    localparam int PIDX_W = $clog2(N_PROC);
    localparam int MIDX_W = $clog2(N_MEM);

    typedef logic [PIDX_W-1:0] pidx_t;
    typedef logic [MIDX_W-1:0] midx_t;

    // Request forwarded through one closed crosspoint to a module
    typedef struct packed {
        logic              valid;
        logic              we;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
    } mreq_t;

    // Per-module record of who owns the return path next cycle
    typedef struct packed {
        logic  valid;
        logic  rd;
        pidx_t owner;
    } route_t;

    function automatic pidx_t next_ptr(pidx_t cur);
        if (int'(cur) == N_PROC - 1) return '0;
        return cur + pidx_t'(1);
    endfunction

endpackage

// File: rtl/pmx_col_decode.sv
module pmx_col_decode
    import pmx_pkg::*;
(
    input  logic [N_PROC-1:0]             p_req,
    input  logic [N_PROC-1:0][MIDX_W-1:0] p_target,
    output logic [N_MEM-1:0][N_PROC-1:0]  req_mat
);
    // Row-to-column request matrix: req_mat[m][p] set when processor p wants m
    always_comb begin
        for (int m = 0; m < N_MEM; m++) begin
            for (int p = 0; p < N_PROC; p++) begin
                req_mat[m][p] = p_req[p] && (p_target[p] == midx_t'(m));
            end
        end
    end
endmodule

// File: rtl/pmx_rr_arb.sv
module pmx_rr_arb
    import pmx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [N_PROC-1:0] req,
    output logic [N_PROC-1:0] gnt,
    output pidx_t             gidx,
    output logic              any
);
    pidx_t ptr_q;

    // Scan upward from the pointer, wrapping, and take the first requester
    always_comb begin
        int j;
        gnt  = '0;
        gidx = '0;
        any  = 1'b0;
        for (int k = 0; k < N_PROC; k++) begin
            j = (int'(ptr_q) + k) % N_PROC;
            if (!any && req[j]) begin
                any    = 1'b1;
                gnt[j] = 1'b1;
                gidx   = pidx_t'(j);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr_q <= '0;
        end else if (any) begin
            ptr_q <= next_ptr(gidx);
        end
    end
endmodule

// File: rtl/pmx_fwd_mux.sv
module pmx_fwd_mux
    import pmx_pkg::*;
(
    input  logic                          any,
    input  pidx_t                         gidx,
    input  logic [N_PROC-1:0]             p_we,
    input  logic [N_PROC-1:0][ADDR_W-1:0] p_addr,
    input  logic [N_PROC-1:0][DATA_W-1:0] p_wdata,
    output mreq_t                         fwd
);
    // One crosspoint column: route the winning row onto the module side
    always_comb begin
        fwd.valid = any;
        fwd.we    = any && p_we[gidx];
        fwd.addr  = any ? p_addr[gidx]  : '0;
        fwd.wdata = any ? p_wdata[gidx] : '0;
    end
endmodule

// File: rtl/pmx_resp_route.sv
module pmx_resp_route
    import pmx_pkg::*;
(
    input  route_t [N_MEM-1:0]             route_q,
    input  logic   [N_MEM-1:0][DATA_W-1:0] m_rdata,
    output logic   [N_PROC-1:0]             p_rvalid,
    output logic   [N_PROC-1:0][DATA_W-1:0] p_rdata
);
    // Return path through the same crosspoint closed on the previous cycle
    always_comb begin
        p_rvalid = '0;
        p_rdata  = '0;
        for (int p = 0; p < N_PROC; p++) begin
            for (int m = 0; m < N_MEM; m++) begin
                if (route_q[m].valid && route_q[m].rd && route_q[m].owner == pidx_t'(p)) begin
                    p_rvalid[p] = 1'b1;
                    p_rdata[p]  = m_rdata[m];
                end
            end
        end
    end
endmodule

// File: rtl/pm_crossbar.sv
module pm_crossbar
    import pmx_pkg::*;
(
    input  logic                          clk,
    input  logic                          rst,
    input  logic [N_PROC-1:0]             p_req,
    input  logic [N_PROC-1:0][MIDX_W-1:0] p_target,
    input  logic [N_PROC-1:0]             p_we,
    input  logic [N_PROC-1:0][ADDR_W-1:0] p_addr,
    input  logic [N_PROC-1:0][DATA_W-1:0] p_wdata,
    output logic [N_PROC-1:0]             p_ready,
    output logic [N_PROC-1:0]             p_rvalid,
    output logic [N_PROC-1:0][DATA_W-1:0] p_rdata,
    output logic [N_MEM-1:0]              m_req,
    output logic [N_MEM-1:0]              m_we,
    output logic [N_MEM-1:0][ADDR_W-1:0]  m_addr,
    output logic [N_MEM-1:0][DATA_W-1:0]  m_wdata,
    input  logic [N_MEM-1:0][DATA_W-1:0]  m_rdata
);
    logic   [N_MEM-1:0][N_PROC-1:0] req_mat;
    logic   [N_MEM-1:0][N_PROC-1:0] gnt_mat;
    pidx_t  [N_MEM-1:0]             col_gidx;
    logic   [N_MEM-1:0]             col_any;
    mreq_t  [N_MEM-1:0]             fwd;
    route_t [N_MEM-1:0]             route_q;

    pmx_col_decode u_decode (
        .p_req    (p_req),
        .p_target (p_target),
        .req_mat  (req_mat)
    );

    for (genvar m = 0; m < N_MEM; m++) begin : g_col
        pmx_rr_arb u_arb (
            .clk  (clk),
            .rst  (rst),
            .req  (req_mat[m]),
            .gnt  (gnt_mat[m]),
            .gidx (col_gidx[m]),
            .any  (col_any[m])
        );

        pmx_fwd_mux u_fwd (
            .any     (col_any[m]),
            .gidx    (col_gidx[m]),
            .p_we    (p_we),
            .p_addr  (p_addr),
            .p_wdata (p_wdata),
            .fwd     (fwd[m])
        );

        assign m_req[m]   = fwd[m].valid;
        assign m_we[m]    = fwd[m].we;
        assign m_addr[m]  = fwd[m].addr;
        assign m_wdata[m] = fwd[m].wdata;

        always_ff @(posedge clk) begin
            if (rst) begin
                route_q[m] <= '0;
            end else begin
                route_q[m].valid <= col_any[m];
                route_q[m].rd    <= col_any[m] && !p_we[col_gidx[m]];
                route_q[m].owner <= col_gidx[m];
            end
        end
    end

    // Row readiness: OR of this processor's crosspoints across all columns
    always_comb begin
        p_ready = '0;
        for (int m = 0; m < N_MEM; m++) begin
            p_ready = p_ready | gnt_mat[m];
        end
    end

    pmx_resp_route u_resp (
        .route_q  (route_q),
        .m_rdata  (m_rdata),
        .p_rvalid (p_rvalid),
        .p_rdata  (p_rdata)
    );
endmodule

// File: rtl/pm_crossbar_chk.sv
module pm_crossbar_chk
    import pmx_pkg::*;
(
    input logic                          clk,
    input logic                          rst,
    input logic [N_PROC-1:0]             p_req,
    input logic [N_PROC-1:0][MIDX_W-1:0] p_target,
    input logic [N_PROC-1:0]             p_we,
    input logic [N_PROC-1:0]             p_ready,
    input logic [N_PROC-1:0]             p_rvalid,
    input logic [N_MEM-1:0]              m_req,
    input logic [N_MEM-1:0][N_PROC-1:0]  gnt_mat
);
    logic [N_PROC-1:0][N_MEM-1:0]  row_v;
    logic [N_MEM-1:0]              wanted;
    logic [N_PROC-1:0][PIDX_W+1:0] wait_cnt;

    always_comb begin
        wanted = '0;
        for (int p = 0; p < N_PROC; p++) begin
            for (int m = 0; m < N_MEM; m++) begin
                row_v[p][m] = gnt_mat[m][p];
            end
            if (p_req[p]) wanted[p_target[p]] = 1'b1;
        end
    end

    for (genvar p = 0; p < N_PROC; p++) begin : g_row
        always_ff @(posedge clk) begin
            if (rst) wait_cnt[p] <= '0;
            else if (p_req[p] && !p_ready[p]) wait_cnt[p] <= wait_cnt[p] + 1'b1;
            else wait_cnt[p] <= '0;
        end

        assert_row_onehot_R8: assert property (@(posedge clk) disable iff (rst)
            $onehot0(row_v[p]));
        assert_ready_needs_req_R2: assert property (@(posedge clk) disable iff (rst)
            p_ready[p] |-> p_req[p]);
        assert_read_returns_R6: assert property (@(posedge clk) disable iff (rst)
            (p_ready[p] && !p_we[p]) |=> p_rvalid[p]);
        assert_rvalid_has_cause_R6: assert property (@(posedge clk) disable iff (rst)
            p_rvalid[p] |-> $past(p_ready[p] && !p_we[p]));
        assert_write_silent_R7: assert property (@(posedge clk) disable iff (rst)
            (p_ready[p] && p_we[p]) |=> !p_rvalid[p]);
        assert_bounded_wait_R9: assert property (@(posedge clk) disable iff (rst)
            int'(wait_cnt[p]) < N_PROC);
    end

    for (genvar m = 0; m < N_MEM; m++) begin : g_colchk
        assert_col_onehot_R8: assert property (@(posedge clk) disable iff (rst)
            $onehot0(gnt_mat[m]));
        assert_served_iff_wanted_R3: assert property (@(posedge clk) disable iff (rst)
            m_req[m] == wanted[m]);
        assert_one_winner_R4: assert property (@(posedge clk) disable iff (rst)
            wanted[m] |-> ($countones(gnt_mat[m]) == 1));
    end
endmodule

bind pm_crossbar pm_crossbar_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .p_req    (p_req),
    .p_target (p_target),
    .p_we     (p_we),
    .p_ready  (p_ready),
    .p_rvalid (p_rvalid),
    .m_req    (m_req),
    .gnt_mat  (gnt_mat)
);

// File: tb/test_pm_crossbar.sv
`timescale 1ns/1ps
module test_pm_crossbar;
    import pmx_pkg::*;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2 clk = ~clk;

    logic [N_PROC-1:0]             p_req = '0;
    logic [N_PROC-1:0][MIDX_W-1:0] p_target = '0;
    logic [N_PROC-1:0]             p_we = '0;
    logic [N_PROC-1:0][ADDR_W-1:0] p_addr = '0;
    logic [N_PROC-1:0][DATA_W-1:0] p_wdata = '0;
    logic [N_PROC-1:0]             p_ready, p_rvalid;
    logic [N_PROC-1:0][DATA_W-1:0] p_rdata;
    logic [N_MEM-1:0]              m_req, m_we;
    logic [N_MEM-1:0][ADDR_W-1:0]  m_addr;
    logic [N_MEM-1:0][DATA_W-1:0]  m_wdata;
    logic [N_MEM-1:0][DATA_W-1:0]  m_rdata = '0;

    pm_crossbar i_pm_crossbar (.*);

    // Behavioural memory stub: 16 words per module, registered read
    logic [DATA_W-1:0] stub [N_MEM][16];
    initial for (int m = 0; m < N_MEM; m++) for (int a = 0; a < 16; a++) stub[m][a] = '0;
    always @(posedge clk) begin
        for (int m = 0; m < N_MEM; m++) begin
            if (m_req[m]) begin
                if (m_we[m]) stub[m][m_addr[m][3:0]] <= m_wdata[m];
                else         m_rdata[m] <= stub[m][m_addr[m][3:0]];
            end
        end
    end

    // Bench model state
    int          ptr [N_MEM];
    logic [31:0] shadow [N_MEM][16];
    bit          pv [N_PROC];
    int          pt [N_PROC];
    bit          pw [N_PROC];
    int          pa [N_PROC];
    logic [31:0] pd [N_PROC];
    int          waitc [N_PROC];
    bit          exp_rv [N_PROC];
    logic [31:0] exp_rd [N_PROC];
    int          owner [N_MEM];
    int          vectors = 0;
    int          miscompares = 0;
    int          stamp = 0;
    bit          done = 1'b0;

    task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic issue(int p, int t, bit w, int a);
        pv[p] = 1'b1; pt[p] = t; pw[p] = w; pa[p] = a;
        stamp++;
        pd[p] = {8'(p), 8'(t), 16'(stamp)};
        waitc[p] = 0;
    endtask

    // One cycle: drive at falling edge, judge this cycle's grants and last cycle's reads
    task automatic step();
        @(negedge clk);
        for (int p = 0; p < N_PROC; p++) begin
            p_req[p]    = pv[p];
            p_target[p] = midx_t'(pt[p]);
            p_we[p]     = pw[p];
            p_addr[p]   = ADDR_W'(pa[p]);
            p_wdata[p]  = pd[p];
        end
        #1;
        for (int p = 0; p < N_PROC; p++) begin
            chk("R6 rvalid", 64'(p_rvalid[p]), 64'(exp_rv[p]));
            if (exp_rv[p]) chk("R6 rdata", 64'(p_rdata[p]), 64'(exp_rd[p]));
        end
        for (int m = 0; m < N_MEM; m++) begin
            owner[m] = -1;
            for (int k = 0; k < N_PROC; k++) begin
                int j = (ptr[m] + k) % N_PROC;
                if (owner[m] < 0 && pv[j] && pt[j] == m) owner[m] = j;
            end
            chk("R3 m_req", 64'(m_req[m]), 64'(owner[m] >= 0));
            if (owner[m] >= 0) begin
                chk("R2 m_we", 64'(m_we[m]), 64'(pw[owner[m]]));
                chk("R2 m_addr", 64'(m_addr[m]), 64'(pa[owner[m]]));
                chk("R2 m_wdata", 64'(m_wdata[m]), 64'(pd[owner[m]]));
            end
        end
        for (int p = 0; p < N_PROC; p++) begin
            bit g = pv[p] && owner[pt[p]] == p;
            chk("R4 p_ready", 64'(p_ready[p]), 64'(g));
            exp_rv[p] = g && !pw[p];
            if (g && !pw[p]) exp_rd[p] = shadow[pt[p]][pa[p] % 16];
        end
        for (int m = 0; m < N_MEM; m++) begin
            if (owner[m] >= 0) begin
                int o = owner[m];
                if (pw[o]) shadow[m][pa[o] % 16] = pd[o];
                ptr[m] = (o + 1) % N_PROC;   // R5
            end
        end
        for (int p = 0; p < N_PROC; p++) begin
            if (pv[p]) begin
                if (owner[pt[p]] == p) pv[p] = 1'b0;
                else begin
                    waitc[p]++;
                    if (waitc[p] >= N_PROC) chk("R9 wait", 64'(waitc[p]), 64'(N_PROC - 1));
                end
            end
        end
    endtask

    function automatic bit any_pending();
        for (int p = 0; p < N_PROC; p++) if (pv[p]) return 1'b1;
        return 1'b0;
    endfunction

    initial begin
        for (int m = 0; m < N_MEM; m++) begin
            ptr[m] = 0;
            for (int a = 0; a < 16; a++) shadow[m][a] = '0;
        end
        for (int p = 0; p < N_PROC; p++) begin
            pv[p] = 0; pt[p] = 0; pw[p] = 0; pa[p] = 0; pd[p] = '0; waitc[p] = 0;
            exp_rv[p] = 0; exp_rd[p] = '0;
        end
        repeat (3) @(negedge clk);
        #1;
        chk("R1 rvalid in reset", 64'(p_rvalid), 64'(0));
        chk("R1 ready in reset", 64'(p_ready), 64'(0));
        @(negedge clk);
        rst = 1'b0;
        #1;
        chk("R1 rvalid after reset", 64'(p_rvalid), 64'(0));

        // Hot spot: all sixteen write to module 5, then all read it back (R1 R4 R5 R7 R6)
        for (int p = 0; p < N_PROC; p++) issue(p, 5, 1'b1, p);
        while (any_pending()) step();
        for (int p = 0; p < N_PROC; p++) issue(N_PROC - 1 - p, 5, 1'b0, p);
        while (any_pending()) step();
        step();

        // Rotating permutations: distinct modules all served at once (R3)
        for (int k = 0; k < N_PROC; k++) begin
            for (int p = 0; p < N_PROC; p++) issue(p, (p * 5 + k) % N_MEM, k[0], (p + k) % 16);
            step();
            chk("R3 all granted", 64'(any_pending()), 64'(0));
        end
        step();

        // Idle gap: pointers must not move (R5), then pair contention on module 9
        repeat (4) step();
        issue(3, 9, 1'b0, 2);
        issue(12, 9, 1'b0, 2);
        step();
        step();

        // Randomized contention over a few hot modules (R4 R5 R6 R7 R9)
        for (int c = 0; c < 3000; c++) begin
            for (int p = 0; p < N_PROC; p++) begin
                if (!pv[p] && ($urandom % 3) != 0)
                    issue(p, (c < 1500) ? int'($urandom % 3) : int'($urandom % N_MEM),
                          bit'($urandom % 2), int'($urandom % 16));
            end
            step();
        end
        while (any_pending()) step();
        step();

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            miscompares++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end
endmodule